// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterizable serial chain of boundary cells wrapped around the functional pins of a chip. There are `N_IN` input cells, which sit between input pins and the core. There are `N_OUT` output cells, which sit between the core and output pins. Every cell holds two flops:

- a capture/shift flop, which takes part in the serial chain;
- an update flop, which is the only stage allowed to drive the cell's output.

A per-cell multiplexer picks either the functional value or the update flop.

All activity runs on one test clock. A data-register clock enable combined with a shift select either loads the parallel inputs or moves the chain one position. An update strobe transfers the chain contents to the update flops. Two mode inputs select, independently for the input side and the output side, whether the update flops drive the outputs. With these controls the block supports:

- normal operation;
- sampling of live pins;
- external test of the board interconnect;
- internal test of an isolated core.

A high-impedance request turns off every output enable. The sequencing of these controls is left to an external test access controller.

Top module: `bscan_chain`

## Requirements
- R1: With `clock_dr_i`=1 and `shift_dr_i`=0 at a clock edge, each input cell loads its pin value `pin_in_i[k]` and each output cell loads its core value `core_out_i[k]`. The result is visible after that edge.
- R2: With `clock_dr_i`=1 and `shift_dr_i`=1 at a clock edge, the chain moves one position. Chain bit 0 (input cell 0) takes `tdi_i`. Chain bit j takes old bit j-1. Chain bits `N_IN-1:0` are the input cells and bits `N_IN+N_OUT-1:N_IN` are the output cells. `tdo_o` always shows the last chain bit.
- R3: With `clock_dr_i`=0 the capture/shift flops hold, whatever `shift_dr_i` and `tdi_i` do.
- R4: An `update_dr_i` edge copies every capture/shift flop into its update flop. Without it the update flops hold, so driven values stay constant while shifting.
- R5: With `mode_in_i`=0, `core_in_o` equals `pin_in_i`. With `mode_out_i`=0, `pin_out_o` equals `core_out_i`. Captures and shifts in this mode change neither output, which is how sampling works.
- R6: With `mode_out_i`=1, `pin_out_o[k]` equals the update flop of output cell k (external test).
- R7: With `mode_in_i`=1, `core_in_o[k]` equals the update flop of input cell k (internal test).
- R8: With `hiz_i`=1 every bit of `pin_oe_o` is 0. With `hiz_i`=0 every bit is 1, independent of the update flops.
- R9: `tst_clr_i`=1 at a clock edge clears all update flops to 0 and takes priority over `update_dr_i`.
- R10: `rst_ni`=0 asynchronously clears both flops of every cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tst_clr_i | input | 1 | Synchronous clear of the update flops |
| clock_dr_i | input | 1 | Capture/shift enable |
| shift_dr_i | input | 1 | 1 selects shift, 0 selects parallel capture |
| update_dr_i | input | 1 | Update strobe |
| mode_in_i | input | 1 | Input cells drive the core from their update flops |
| mode_out_i | input | 1 | Output cells drive the pins from their update flops |
| hiz_i | input | 1 | Force all output enables low |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| pin_in_i | input | N_IN | Values arriving at the input pins |
| core_in_o | output | N_IN | Values delivered to the core |
| core_out_i | input | N_OUT | Values produced by the core |
| pin_out_o | output | N_OUT | Values driven to the output pins |
| pin_oe_o | output | N_OUT | Output enables of the output pins |

## Verification
Capture, shift, update and clear each act on a single clock edge. Their results appear at the ports one edge later. The multiplexers, `tdo_o` and the enables are combinational.

The bench changes inputs and strobes on the falling edge and samples at the following falling edge, after exactly one rising edge. This means every registered result is due at the first sample after its strobe. Serial readout takes `tdo_o` before each shift edge, so it sees the chain contents from before that edge.

Chain patterns and pin/core patterns are swept exhaustively at the default-sized small configuration.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    CAP_HOLD  = 2'd0,
    CAP_LOAD  = 2'd1,
    CAP_SHIFT = 2'd2
  } cap_op_e;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_LOAD  = 2'd1,
    UPD_CLEAR = 2'd2
  } upd_op_e;
endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic    clock_dr_i,
  input  logic    shift_dr_i,
  input  logic    update_dr_i,
  input  logic    tst_clr_i,
  output cap_op_e cap_op_o,
  output upd_op_e upd_op_o
);
  always_comb begin
    if (!clock_dr_i)     cap_op_o = CAP_HOLD;
    else if (shift_dr_i) cap_op_o = CAP_SHIFT;
    else                 cap_op_o = CAP_LOAD;
  end

  // clear wins over update
  always_comb begin
    if (tst_clr_i)        upd_op_o = UPD_CLEAR;
    else if (update_dr_i) upd_op_o = UPD_LOAD;
    else                  upd_op_o = UPD_HOLD;
  end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cap_op_e cap_op_i,
  input  upd_op_e upd_op_i,
  input  logic    mode_i,
  input  logic    par_i,
  input  logic    ser_i,
  output logic    cap_o,
  output logic    out_o
);
  logic cap_q, upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else begin
      unique case (cap_op_i)
        CAP_LOAD:  cap_q <= par_i;
        CAP_SHIFT: cap_q <= ser_i;
        default:   cap_q <= cap_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else begin
      unique case (upd_op_i)
        UPD_LOAD:  upd_q <= cap_q;
        UPD_CLEAR: upd_q <= 1'b0;
        default:   upd_q <= upd_q;
      endcase
    end
  end

  assign cap_o = cap_q;
  assign out_o = mode_i ? upd_q : par_i;

  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_op_i == CAP_LOAD |=> cap_q == $past(par_i));
  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_op_i == CAP_SHIFT |=> cap_q == $past(ser_i));
  assert_cap_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_op_i == CAP_HOLD |=> $stable(cap_q));
  assert_upd_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_op_i == UPD_LOAD |=> upd_q == $past(cap_q));
  assert_upd_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_op_i == UPD_HOLD |=> $stable(upd_q));
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_op_i == UPD_CLEAR |=> upd_q == 1'b0);
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_OUT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tst_clr_i,
  input  logic             clock_dr_i,
  input  logic             shift_dr_i,
  input  logic             update_dr_i,
  input  logic             mode_in_i,
  input  logic             mode_out_i,
  input  logic             hiz_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] pin_out_o,
  output logic [N_OUT-1:0] pin_oe_o
);
  localparam int NC = N_IN + N_OUT;

  cap_op_e cap_op;
  upd_op_e upd_op;
  logic [NC-1:0] chain;

  bscan_ctrl u_ctrl (
    .clock_dr_i (clock_dr_i),
    .shift_dr_i (shift_dr_i),
    .update_dr_i(update_dr_i),
    .tst_clr_i  (tst_clr_i),
    .cap_op_o   (cap_op),
    .upd_op_o   (upd_op)
  );

  for (genvar k = 0; k < NC; k++) begin : g_cell
    logic ser;
    if (k == 0) begin : g_head
      assign ser = tdi_i;
    end else begin : g_link
      assign ser = chain[k-1];
    end

    if (k < N_IN) begin : g_in
      bscan_cell u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cap_op_i(cap_op),
        .upd_op_i(upd_op),
        .mode_i  (mode_in_i),
        .par_i   (pin_in_i[k]),
        .ser_i   (ser),
        .cap_o   (chain[k]),
        .out_o   (core_in_o[k])
      );
    end else begin : g_out
      bscan_cell u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cap_op_i(cap_op),
        .upd_op_i(upd_op),
        .mode_i  (mode_out_i),
        .par_i   (core_out_i[k-N_IN]),
        .ser_i   (ser),
        .cap_o   (chain[k]),
        .out_o   (pin_out_o[k-N_IN])
      );
      assign pin_oe_o[k-N_IN] = ~hiz_i;
    end
  end

  assign tdo_o = chain[NC-1];

  assert_tdo_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clock_dr_i && shift_dr_i) |=> tdo_o == $past(chain[NC-2]));
  assert_extest_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_out_i && !update_dr_i && !tst_clr_i) ##1 mode_out_i |-> $stable(pin_out_o));
endmodule

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
  localparam int NI = 3;
  localparam int NO = 3;
  localparam int NC = NI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tst_clr = 0, clock_dr = 0, shift_dr = 0, update_dr = 0;
  logic mode_in = 0, mode_out = 0, hiz = 0, tdi = 0;
  logic tdo;
  logic [NI-1:0] pin_in = '0, core_in;
  logic [NO-1:0] core_out = '0, pin_out, pin_oe;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tst_clr_i(tst_clr), .clock_dr_i(clock_dr),
    .shift_dr_i(shift_dr), .update_dr_i(update_dr), .mode_in_i(mode_in),
    .mode_out_i(mode_out), .hiz_i(hiz), .tdi_i(tdi), .tdo_o(tdo),
    .pin_in_i(pin_in), .core_in_o(core_in), .core_out_i(core_out),
    .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one strobe cycle, ends at the next falling edge
  task automatic strobe(input logic s, input logic c, input logic u, input logic t);
    @(negedge clk);
    shift_dr = s; clock_dr = c; update_dr = u; tst_clr = t;
    @(negedge clk);
    shift_dr = 0; clock_dr = 0; update_dr = 0; tst_clr = 0;
  endtask

  // shift NC bits in; returns the chain content present before shifting
  task automatic shift_vec(input logic [NC-1:0] v, output logic [NC-1:0] got);
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      got[NC-1-i] = tdo;
      tdi = v[NC-1-i]; shift_dr = 1; clock_dr = 1;
      @(negedge clk);
    end
    shift_dr = 0; clock_dr = 0; tdi = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NC-1:0] got;
    logic [NC-1:0] prev;
    pin_in = 3'b110; core_out = 3'b011;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 tdo", tdo, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R5 core_in pass", core_in, 3'b110);
    chk("R5 pin_out pass", pin_out, 3'b011);
    chk("R8 oe on", pin_oe, 3'b111);
    hiz = 1; #1;
    chk("R8 oe off", pin_oe, 3'b000);
    hiz = 0;

    // R1/R5 capture sweep in sample mode
    for (int v = 0; v < 64; v++) begin
      pin_in = v[NI-1:0]; core_out = v[NC-1:NI];
      strobe(0, 1, 0, 0);
      chk("R5 sample core_in", core_in, v[NI-1:0]);
      chk("R5 sample pin_out", pin_out, v[NC-1:NI]);
      shift_vec('0, got);
      chk("R1 captured chain", got, v[NC-1:0]);
    end

    // R3 shift select without enable does nothing
    pin_in = 3'b101; core_out = 3'b010;
    strobe(0, 1, 0, 0);
    @(negedge clk);
    tdi = 1; shift_dr = 1;
    repeat (4) @(negedge clk);
    shift_dr = 0; tdi = 0;
    shift_vec('0, got);
    chk("R3 hold without enable", got, 6'b010101);

    // R2 shift order: chain fully shifted through
    shift_vec(6'b100110, got);
    shift_vec('0, got);
    chk("R2 shift through", got, 6'b100110);

    // R4/R6/R7 test-mode sweep
    mode_in = 1; mode_out = 1;
    strobe(0, 0, 1, 0); // update flops get zeros
    prev = '0;
    for (int p = 0; p < 64; p++) begin
      shift_vec(p[NC-1:0], got);
      chk("R4 core_in stable in shift", core_in, prev[NI-1:0]);
      chk("R4 pin_out stable in shift", pin_out, prev[NC-1:NI]);
      strobe(0, 0, 1, 0);
      chk("R7 intest core_in", core_in, p[NI-1:0]);
      chk("R6 extest pin_out", pin_out, p[NC-1:NI]);
      prev = p[NC-1:0];
    end
    chk("R6 pin stays under pin change", pin_out, 3'b111);
    hiz = 1; #1;
    chk("R8 oe off with update set", pin_oe, 3'b000);
    hiz = 0;

    // R9 clear wins over update
    shift_vec(6'b111111, got);
    strobe(0, 0, 1, 1);
    chk("R9 clear core_in", core_in, 0);
    chk("R9 clear pin_out", pin_out, 0);

    // R10 async reset clears chain
    @(negedge clk);
    rst_n = 0; #1;
    chk("R10 tdo async", tdo, 0);
    @(negedge clk); rst_n = 1;
    shift_vec('0, got);
    chk("R10 chain cleared", got, 0);
    mode_in = 0; mode_out = 0; pin_in = 3'b011; core_out = 3'b100; #1;
    chk("R5 normal core_in", core_in, 3'b011);
    chk("R5 normal pin_out", pin_out, 3'b100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule